// File: doc/BRIEF.md
# Gated Multichannel DAC Code Bank

This block holds the digital codes for eight digital-to-analog output channels and decides when those codes reach the converter pins. Software writes a 14-bit code for each channel over a 16-bit register bus. A separate 32-bit control word has two writable bits. One is a load-hold bit and the other is an output-enable bit. Together they gate whether codes pass straight to the outputs, are held back, or are replaced by the ground code.

The outputs follow the stored codes only while the hold bit is clear and the enable bit is set. In that "live" state, a channel write reaches that channel's pin on the next clock. In any other state, a code write only updates storage. A control-word write that lands in the live state copies all eight stored codes to the pins at once. Clearing the enable bit drives every pin to code 0. The stored codes are kept, and they come back at the next flush.

Each channel has a one-cycle strobe that a converter can use as a latch pulse. The register bus never stalls: every write completes in the cycle it is presented, and reads are combinational. Because nothing upstream can be held off, the interface has no valid/ready handshake.

Top module: `dac_gate_bank`

## Requirements
- R1: After reset, every stored code and every output bus holds 0x3FFF, all strobes are 0, and the control word reads 0x060006C0.
- R2: Channel k's code register sits at byte offset 0x20 + 2*k (k = 0..7). A write to any other offset, odd offsets included, changes no code and no output. A read of any other offset returns 0.
- R3: A code write stores only bits [13:0] of the write data. A read returns the stored code with bits [15:14] zero.
- R4: A control-word write changes only bit 23 (hold) and bit 26 (enable). Every other bit always reads back as in 0x060006C0.
- R5: While the control word has bit 23 = 0 and bit 26 = 1 (live), a code write to channel k appears on channel k's output bus on the next clock edge.
- R6: While the control word is not live, a code write is stored but leaves the output bus unchanged.
- R7: A control-word write whose new value is live drives all eight stored codes onto the outputs on the next clock edge.
- R8: A control-word write with bit 26 = 0 forces all eight outputs to 0. Stored codes are kept and read back unchanged, and they reappear after the next live control write.
- R9: A channel's strobe is high for exactly one cycle after each edge that drives its output (a live code write, a flush, or forcing to ground), and is low otherwise.
- R10: A control-word write with bit 23 = 1 and bit 26 = 1 leaves every output unchanged and raises no strobe.
- R11: When a code write and a live control-word write occur in the same cycle, the flushed output for that channel carries the newly written code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Code register write this cycle |
| bus_addr | input | 8 | Byte offset for code write and read |
| bus_wdata | input | 16 | Code write data |
| bus_rdata | output | 16 | Combinational read of the addressed code |
| ctl_wr | input | 1 | Control word write this cycle |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Current control word |
| dac_out | output | 112 | Eight 14-bit output codes, channel k at [14k+13:14k] |
| dac_stb | output | 8 | Per-channel output refresh strobe |

## Verification
The assertions assume that bus_wr and ctl_wr are always known and are sampled only outside reset. They also assume that any change to dac_out is caused by one of the two writes in the cycle before. The stimulus drives every input to a defined value on the falling edge and drops both write enables after one cycle. Code writes and control writes occur in the same cycle only in the single case that exercises R11. Addresses outside the channel window are driven on purpose, so the decode checks see real traffic.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int unsigned CTL_W       = 32;
  localparam int unsigned HOLD_BIT    = 23;
  localparam int unsigned ENABLE_BIT  = 26;
  localparam logic [CTL_W-1:0] CTL_RESET = 32'h0600_06C0;
  localparam logic [CTL_W-1:0] CTL_WMASK = (32'h1 << HOLD_BIT) | (32'h1 << ENABLE_BIT);
  localparam logic [CTL_W-1:0] CTL_FIXED = CTL_RESET & ~CTL_WMASK;
endpackage

// File: rtl/dacbank_ctl.sv
module dacbank_ctl
  import dacbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic             live,
  output logic             flush,
  output logic             ground
);
  logic [CTL_W-1:0] ctl_next;

  assign ctl_next = (wdata & CTL_WMASK) | CTL_FIXED;
  assign live     = ~ctl_q[HOLD_BIT] & ctl_q[ENABLE_BIT];
  assign flush    = wr & ~ctl_next[HOLD_BIT] & ctl_next[ENABLE_BIT];
  assign ground   = wr & ~ctl_next[ENABLE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)  ctl_q <= CTL_RESET;
    else if (wr) ctl_q <= ctl_next;
  end
endmodule

// File: rtl/dacbank_decode.sv
module dacbank_decode #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 32'h20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] sel
);
  localparam int unsigned STRIDE = 2;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
    assign sel[k] = (addr == ADDR_W'(BASE + STRIDE * k));
  end
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
  parameter int unsigned CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CODE_W-1:0] wdata,
  input  logic              live,
  input  logic              ctl_wr,
  input  logic              flush,
  input  logic              ground,
  output logic [CODE_W-1:0] code_q,
  output logic [CODE_W-1:0] out_q,
  output logic              stb_q
);
  localparam logic [CODE_W-1:0] RESET_CODE = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_next;

  assign code_next = wr_hit ? wdata : code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= RESET_CODE;
      out_q  <= RESET_CODE;
      stb_q  <= 1'b0;
    end else begin
      code_q <= code_next;
      stb_q  <= 1'b0;
      if (ground) begin
        out_q <= '0;
        stb_q <= 1'b1;
      end else if (flush) begin
        out_q <= code_next;
        stb_q <= 1'b1;
      end else if (!ctl_wr && wr_hit && live) begin
        out_q <= wdata;
        stb_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_gate_bank.sv
module dac_gate_bank
  import dacbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 14,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 32'h20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [BUS_W-1:0]         bus_wdata,
  output logic [BUS_W-1:0]         bus_rdata,
  input  logic                     ctl_wr,
  input  logic [CTL_W-1:0]         ctl_wdata,
  output logic [CTL_W-1:0]         ctl_rdata,
  output logic [NUM_CH*CODE_W-1:0] dac_out,
  output logic [NUM_CH-1:0]        dac_stb
);
  logic [NUM_CH-1:0] sel;
  logic [CODE_W-1:0] code_q [NUM_CH];
  logic              live, flush, ground;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:CODE_W];

  dacbank_ctl u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ctl_wr),
    .wdata  (ctl_wdata),
    .ctl_q  (ctl_rdata),
    .live   (live),
    .flush  (flush),
    .ground (ground)
  );

  dacbank_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    dacbank_chan #(.CODE_W(CODE_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (bus_wr & sel[k]),
      .wdata  (bus_wdata[CODE_W-1:0]),
      .live   (live),
      .ctl_wr (ctl_wr),
      .flush  (flush),
      .ground (ground),
      .code_q (code_q[k]),
      .out_q  (dac_out[k*CODE_W +: CODE_W]),
      .stb_q  (dac_stb[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (sel[k]) bus_rdata[CODE_W-1:0] = code_q[k];
    end
  end
endmodule

// File: rtl/dac_gate_bank_chk.sv
module dac_gate_bank_chk
  import dacbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 14,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 32'h20
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [BUS_W-1:0]         bus_wdata,
  input logic                     ctl_wr,
  input logic [CTL_W-1:0]         ctl_rdata,
  input logic [NUM_CH*CODE_W-1:0] dac_out,
  input logic [NUM_CH-1:0]        dac_stb
);
  // R4: bits other than hold and enable never move
  assert_fixed_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata & ~CTL_WMASK) == CTL_FIXED);

  // R8: enable low means every output sits at the ground code
  assert_ground_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[ENABLE_BIT] |-> (dac_out == '0));

  // R9: a strobe only follows a write of some kind
  assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_stb != '0) |-> $past(ctl_wr || bus_wr));

  // R6: with no write in the previous cycle the outputs stay put
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_wr || bus_wr) |-> $stable(dac_out));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    // R5: live code write reaches the pin one edge later
    assert_live_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !ctl_wr && bus_addr == ADDR_W'(BASE + 2 * k) &&
       !ctl_rdata[HOLD_BIT] && ctl_rdata[ENABLE_BIT])
      |=> (dac_out[k*CODE_W +: CODE_W] == $past(bus_wdata[CODE_W-1:0])) && dac_stb[k]);
  end
endmodule

bind dac_gate_bank dac_gate_bank_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ctl_wr    (ctl_wr),
  .ctl_rdata (ctl_rdata),
  .dac_out   (dac_out),
  .dac_stb   (dac_stb)
);

// File: tb/dac_gate_bank_bench.sv
module dac_gate_bank_bench;
  localparam int unsigned NCH = 8;
  localparam int unsigned CW  = 14;

  typedef struct packed {
    logic        is_ctl;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [2:0]  ch;
    logic [13:0] exp_out;
    logic        exp_stb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h20, 32'h0000_1234, 3'd0, 14'h1234, 1'b1}, // R5
    '{1'b0, 8'h2E, 32'h0000_FFFF, 3'd7, 14'h3FFF, 1'b1}, // R3
    '{1'b0, 8'h26, 32'h0000_C001, 3'd3, 14'h0001, 1'b1}, // R3
    '{1'b1, 8'h00, 32'h0480_0000, 3'd0, 14'h1234, 1'b0}, // R10
    '{1'b0, 8'h20, 32'h0000_0AAA, 3'd0, 14'h1234, 1'b0}, // R6
    '{1'b1, 8'h00, 32'h0400_0000, 3'd0, 14'h0AAA, 1'b1}, // R7
    '{1'b1, 8'h00, 32'h0000_0000, 3'd0, 14'h0000, 1'b1}, // R8
    '{1'b0, 8'h22, 32'h0000_0555, 3'd1, 14'h0000, 1'b0}, // R6
    '{1'b1, 8'h00, 32'h0400_0000, 3'd1, 14'h0555, 1'b1}, // R8
    '{1'b0, 8'h21, 32'h0000_0111, 3'd0, 14'h0AAA, 1'b0}, // R2
    '{1'b0, 8'h30, 32'h0000_0222, 3'd7, 14'h3FFF, 1'b0}, // R2
    '{1'b0, 8'h2A, 32'h0000_2000, 3'd5, 14'h2000, 1'b1}  // R5
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_wr;
  logic [7:0]      bus_addr;
  logic [15:0]     bus_wdata;
  logic [15:0]     bus_rdata;
  logic            ctl_wr;
  logic [31:0]     ctl_wdata;
  logic [31:0]     ctl_rdata;
  logic [NCH*CW-1:0] dac_out;
  logic [NCH-1:0]  dac_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dac_gate_bank u_dac_gate_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .dac_out(dac_out), .dac_stb(dac_stb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] outc(input int ch);
    return dac_out[ch*CW +: CW];
  endfunction

  // drive one cycle of writes at the falling edge, sample at the next falling edge
  task automatic apply(input logic bw, input logic cw, input logic [7:0] a,
                       input logic [15:0] bd, input logic [31:0] cd);
    @(negedge clk);
    bus_wr = bw; ctl_wr = cw; bus_addr = a; bus_wdata = bd; ctl_wdata = cd;
    @(negedge clk);
    bus_wr = 1'b0; ctl_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_addr = a;
    #1;
  endtask

  initial begin
    bus_wr = 1'b0; ctl_wr = 1'b0; bus_addr = '0; bus_wdata = '0; ctl_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ctl", ctl_rdata, 32'h0600_06C0);
    check("R1 stb", {24'h0, dac_stb}, 32'h0);
    for (int k = 0; k < NCH; k++) begin
      check("R1 out", {18'h0, outc(k)}, 32'h3FFF);
      rd(8'(8'h20 + 2 * k));
      check("R1 code", {16'h0, bus_rdata}, 32'h3FFF);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(!TBL[i].is_ctl, TBL[i].is_ctl, TBL[i].addr, TBL[i].data[15:0], TBL[i].data);
      check($sformatf("table row %0d out", i), {18'h0, outc(TBL[i].ch)}, {18'h0, TBL[i].exp_out});
      check($sformatf("table row %0d stb", i), {31'h0, dac_stb[TBL[i].ch]}, {31'h0, TBL[i].exp_stb});
    end

    // R9 strobe is a single-cycle pulse
    apply(1'b1, 1'b0, 8'h28, 16'h0100, 32'h0);
    check("R9 pulse", {24'h0, dac_stb}, 32'h10);
    @(negedge clk);
    check("R9 drop", {24'h0, dac_stb}, 32'h0);

    // R3 read-back and R2 unmapped reads
    rd(8'h26); check("R3 read ch3", {16'h0, bus_rdata}, 32'h0001);
    rd(8'h2E); check("R3 read ch7", {16'h0, bus_rdata}, 32'h3FFF);
    rd(8'h30); check("R2 read unmapped", {16'h0, bus_rdata}, 32'h0);
    rd(8'h21); check("R2 read odd", {16'h0, bus_rdata}, 32'h0);
    rd(8'h20); check("R2 odd write ignored", {16'h0, bus_rdata}, 32'h0AAA);

    // R4 masked control writes
    apply(1'b0, 1'b1, 8'h00, 16'h0, 32'hFFFF_FFFF);
    check("R4 all ones", ctl_rdata, 32'h0680_06C0);
    check("R10 hold keeps ch4", {18'h0, outc(4)}, 32'h0100);
    apply(1'b0, 1'b1, 8'h00, 16'h0, 32'h0000_0000);
    check("R4 all zeros", ctl_rdata, 32'h0200_06C0);
    check("R8 ground all", {16'h0, dac_out[15:0]} | 32'(|dac_out), 32'h0);
    check("R9 ground strobes", {24'h0, dac_stb}, 32'hFF);
    rd(8'h20); check("R8 code kept", {16'h0, bus_rdata}, 32'h0AAA);

    // R11 simultaneous code write and live flush
    apply(1'b1, 1'b1, 8'h24, 16'h0777, 32'h0400_0000);
    check("R11 ch2 new code", {18'h0, outc(2)}, 32'h0777);
    check("R11 strobes", {24'h0, dac_stb}, 32'hFF);
    begin
      logic [13:0] expv [NCH] = '{14'h0AAA, 14'h0555, 14'h0777, 14'h0001,
                                  14'h0100, 14'h2000, 14'h3FFF, 14'h3FFF};
      for (int k = 0; k < NCH; k++)
        check($sformatf("R7 flush ch%0d", k), {18'h0, outc(k)}, {18'h0, expv[k]});
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule